// File: doc/BRIEF.md
# Interleaved Per-Channel Parity Checker

This block watches a multiplexed byte stream in which many independent channels take turns one byte at a time. Two bytes arrive on each clock, so each clock carries one even-numbered channel and the odd channel after it. For every channel the block keeps a running bit-by-bit parity byte, which is the XOR of that channel's bytes. Once per channel frame the stream carries a parity byte at a fixed position. The block compares it with the accumulated value and reports the result with the channel index. Each lane has its own report path, so two channels can report in the same clock.

The caller marks the first beat of every multiplexed frame with `frame_start`. From that marker the block counts channel pairs and byte positions itself. A channel frame is `ROWS*COLS` bytes long, and the parity byte sits at position `PAR_POS` within it. Sequencing is handled by a three-state machine:

- HUNT: the state after reset. It ignores data until a valid beat carries `frame_start` (transition HUNT→PRIME).
- PRIME: the block accumulates and restarts each accumulator at its parity byte, but reports nothing. When the parity position of the last channel pair has been consumed, it moves to CHECK (transition PRIME→CHECK).
- CHECK: every parity position yields a report. This state is held until reset. A `frame_start` here only realigns the counters.

Top module: `ilv_parity_checker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both report strobes and both error flags are low.
- R2: On the beat that carries `frame_start`, the pair index is 0. It advances by one per accepted beat and wraps at NUM_CH/2. On pair index j, lane 0 holds channel 2j and lane 1 holds channel 2j+1. A report on lane 0 carries channel 2j, and a report on lane 1 carries channel 2j+1.
- R3: The byte position is 0 on the `frame_start` beat. It advances by one each time the pair index wraps, and returns to 0 after ROWS*COLS-1. Reports occur only on beats at position PAR_POS.
- R4: The error flag is 1 exactly when the received parity byte differs in at least one bit from the XOR of that channel's bytes. The XOR covers the previous parity byte (inclusive) up to the byte just before the current one.
- R5: No report is made on beats before the first valid `frame_start` after reset, or during the first frame. The first frame's parity bytes restart every accumulator.
- R6: A beat with `in_valid` low has no effect: it produces no report, the counters hold, the accumulators hold, and `frame_start` on such a beat is ignored.
- R7: A report appears in the clock cycle right after the accepted beat. The error flag is never high without the strobe.
- R8: Both lanes report in the same cycle when their parity positions coincide, and each lane has its own error flag.
- R9: A valid `frame_start` that arrives in mid-frame realigns pair and position to 0 and leaves the accumulators untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat holds two valid bytes |
| frame_start | input | 1 | Beat is the first of a multiplexed frame |
| lane0_byte | input | 8 | Byte for the even channel |
| lane1_byte | input | 8 | Byte for the odd channel |
| chk0_valid | output | 1 | Lane 0 parity report strobe |
| chk0_chan | output | $clog2(NUM_CH) | Channel index of the lane 0 report |
| chk0_err | output | 1 | Lane 0 frame parity mismatch |
| chk1_valid | output | 1 | Lane 1 parity report strobe |
| chk1_chan | output | $clog2(NUM_CH) | Channel index of the lane 1 report |
| chk1_err | output | 1 | Lane 1 frame parity mismatch |

## Verification
The bench builds the block with 4 channels, 3 rows by 4 columns and the parity byte at position 5. A multiplexed frame is therefore only 24 beats long. With these values, many frames fit into a short run, both pair-index wraps and position wraps occur often, and a mid-frame realignment can be set up to land before or after a parity position. The small channel count also makes both lanes hit their parity bytes in many beats. This lets simultaneous mismatches, clean frames and gapped streams all occur many times.

// File: rtl/ilv_par_pkg.sv
package ilv_par_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_PRIME = 2'd1,
        ST_CHECK = 2'd2
    } trk_state_t;

    localparam int LANES = 2;

endpackage

// File: rtl/ilv_beat_tracker.sv
module ilv_beat_tracker
    import ilv_par_pkg::*;
#(
    parameter int NUM_CH      = 192,
    parameter int FRAME_BYTES = 810,
    parameter int PAR_POS     = 4,
    parameter int PAIR_W      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              frame_start,
    output logic              take,
    output logic              at_par,
    output logic              check_en,
    output logic [PAIR_W-1:0] pair_idx,
    output trk_state_t        state_o
);

    localparam int PAIRS = NUM_CH / 2;
    localparam int POS_W = $clog2(FRAME_BYTES);
    localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(PAIRS - 1);
    localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(FRAME_BYTES - 1);
    localparam logic [POS_W-1:0]  PAR_P     = POS_W'(PAR_POS);

    trk_state_t        state_q, state_d;
    logic [PAIR_W-1:0] pair_q, eff_pair, nxt_pair;
    logic [POS_W-1:0]  pos_q, eff_pos, nxt_pos;
    logic              last_pair;

    // Realignment: a valid frame marker makes this beat pair 0, position 0
    always_comb begin
        eff_pair  = (frame_start) ? '0 : pair_q;
        eff_pos   = (frame_start) ? '0 : pos_q;
        last_pair = (eff_pair == LAST_PAIR);
        nxt_pair  = last_pair ? '0 : eff_pair + 1'b1;
        if (!last_pair)
            nxt_pos = eff_pos;
        else if (eff_pos == LAST_POS)
            nxt_pos = '0;
        else
            nxt_pos = eff_pos + 1'b1;
    end

    always_comb begin
        take     = in_valid && ((state_q != ST_HUNT) || frame_start);
        at_par   = take && (eff_pos == PAR_P);
        check_en = (state_q == ST_CHECK);
        pair_idx = eff_pair;
        state_o  = state_q;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (in_valid && frame_start) state_d = ST_PRIME;
            ST_PRIME: if (at_par && last_pair)     state_d = ST_CHECK;
            ST_CHECK: state_d = ST_CHECK;
            default:  state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q <= '0;
            pos_q  <= '0;
        end else if (take) begin
            pair_q <= nxt_pair;
            pos_q  <= nxt_pos;
        end
    end

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pair_q) && $stable(pos_q) && $stable(state_q)));

    // R2
    pair_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_q <= LAST_PAIR);

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST_POS);

endmodule

// File: rtl/ilv_lane_parity.sv
module ilv_lane_parity #(
    parameter int LANE   = 0,
    parameter int NUM_CH = 192,
    parameter int PAIR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              at_par,
    input  logic              check_en,
    input  logic [PAIR_W-1:0] pair_idx,
    input  logic [7:0]        data,
    output logic              rpt_valid,
    output logic [PAIR_W:0]   rpt_chan,
    output logic              rpt_err
);

    localparam int   PAIRS    = NUM_CH / 2;
    localparam logic LANE_BIT = 1'(LANE);

    logic [7:0] acc_q [PAIRS];
    logic [7:0] acc_cur;
    logic       hit, mismatch;

    always_comb begin
        acc_cur  = acc_q[pair_idx];
        hit      = at_par && check_en;
        mismatch = (acc_cur != data);
    end

    // Accumulator bank: one parity byte per channel served by this lane
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAIRS; i++) acc_q[i] <= '0;
        end else if (take) begin
            acc_q[pair_idx] <= at_par ? data : (acc_cur ^ data);
        end
    end

    // Report outputs, one clock behind the beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rpt_valid <= 1'b0;
            rpt_err   <= 1'b0;
            rpt_chan  <= '0;
        end else begin
            rpt_valid <= hit;
            rpt_err   <= hit && mismatch;
            rpt_chan  <= {pair_idx, LANE_BIT};
        end
    end

    // R7
    err_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_err |-> rpt_valid);

    // R2
    lane_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> (rpt_chan[0] == LANE_BIT));

endmodule

// File: rtl/ilv_parity_checker.sv
module ilv_parity_checker
    import ilv_par_pkg::*;
#(
    parameter int NUM_CH  = 192,
    parameter int ROWS    = 9,
    parameter int COLS    = 90,
    parameter int PAR_POS = 4,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            frame_start,
    input  logic [7:0]      lane0_byte,
    input  logic [7:0]      lane1_byte,
    output logic            chk0_valid,
    output logic [CH_W-1:0] chk0_chan,
    output logic            chk0_err,
    output logic            chk1_valid,
    output logic [CH_W-1:0] chk1_chan,
    output logic            chk1_err
);

    localparam int FRAME_BYTES = ROWS * COLS;
    localparam int PAIR_W      = CH_W - 1;

    logic              take, at_par, check_en;
    logic [PAIR_W-1:0] pair_idx;
    trk_state_t        trk_state;

    logic [7:0]      lane_data [LANES];
    logic            lane_vld  [LANES];
    logic [CH_W-1:0] lane_chan [LANES];
    logic            lane_err  [LANES];

    assign lane_data[0] = lane0_byte;
    assign lane_data[1] = lane1_byte;

    ilv_beat_tracker #(
        .NUM_CH      (NUM_CH),
        .FRAME_BYTES (FRAME_BYTES),
        .PAR_POS     (PAR_POS),
        .PAIR_W      (PAIR_W)
    ) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .frame_start (frame_start),
        .take        (take),
        .at_par      (at_par),
        .check_en    (check_en),
        .pair_idx    (pair_idx),
        .state_o     (trk_state)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ilv_lane_parity #(
            .LANE   (l),
            .NUM_CH (NUM_CH),
            .PAIR_W (PAIR_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .take      (take),
            .at_par    (at_par),
            .check_en  (check_en),
            .pair_idx  (pair_idx),
            .data      (lane_data[l]),
            .rpt_valid (lane_vld[l]),
            .rpt_chan  (lane_chan[l]),
            .rpt_err   (lane_err[l])
        );
    end

    assign chk0_valid = lane_vld[0];
    assign chk0_chan  = lane_chan[0];
    assign chk0_err   = lane_err[0];
    assign chk1_valid = lane_vld[1];
    assign chk1_chan  = lane_chan[1];
    assign chk1_err   = lane_err[1];

    // R8
    lanes_paired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk0_valid == chk1_valid);

    // R7
    report_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk0_valid |-> $past(in_valid));

    // R5
    quiet_until_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_state != ST_CHECK) |=> (!chk0_valid && !chk1_valid));

endmodule

// File: tb/ilv_parity_checker_tb.sv
module ilv_parity_checker_tb;

    localparam int NCH = 4;
    localparam int RW  = 3;
    localparam int CL  = 4;
    localparam int PP  = 5;
    localparam int FB  = RW * CL;
    localparam int NP  = NCH / 2;
    localparam int CW  = $clog2(NCH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          frame_start = 1'b0;
    logic [7:0]    lane0_byte = '0;
    logic [7:0]    lane1_byte = '0;
    logic          chk0_valid, chk0_err, chk1_valid, chk1_err;
    logic [CW-1:0] chk0_chan, chk1_chan;

    always #2 clk = ~clk;

    ilv_parity_checker #(.NUM_CH(NCH), .ROWS(RW), .COLS(CL), .PAR_POS(PP)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_start(frame_start),
        .lane0_byte(lane0_byte), .lane1_byte(lane1_byte),
        .chk0_valid(chk0_valid), .chk0_chan(chk0_chan), .chk0_err(chk0_err),
        .chk1_valid(chk1_valid), .chk1_chan(chk1_chan), .chk1_err(chk1_err)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // reference model: 0 hunt, 1 prime, 2 check
    int         m_st;
    int         m_pair;
    int         m_pos;
    logic [7:0] m_acc [NCH];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] flip(int pct);
        if (($urandom % 100) < pct) return 8'(1 << ($urandom % 8));
        return 8'h00;
    endfunction

    task automatic beat(bit v, bit fs, int cor, string tag);
        bit tk, par, rpt;
        int ep, epos;
        int ch [2];
        logic [7:0] b [2];
        bit e [2];
        tk   = v && (m_st != 0 || fs);
        ep   = fs ? 0 : m_pair;
        epos = fs ? 0 : m_pos;
        par  = tk && (epos == PP);
        rpt  = par && (m_st == 2);
        for (int l = 0; l < 2; l++) begin
            ch[l] = 2 * ep + l;
            if (epos == PP) b[l] = m_acc[ch[l]] ^ flip(cor);
            else            b[l] = 8'($urandom);
            e[l] = rpt && (b[l] != m_acc[ch[l]]);
        end
        @(negedge clk);
        in_valid    = v;
        frame_start = fs;
        lane0_byte  = b[0];
        lane1_byte  = b[1];
        @(posedge clk);
        #1;
        if (tk) begin
            for (int l = 0; l < 2; l++)
                m_acc[ch[l]] = par ? b[l] : (m_acc[ch[l]] ^ b[l]);
            if (m_st == 0) m_st = 1;
            else if (m_st == 1 && par && ep == NP - 1) m_st = 2;
            if (ep == NP - 1) begin
                m_pair = 0;
                m_pos  = (epos == FB - 1) ? 0 : epos + 1;
            end else begin
                m_pair = ep + 1;
                m_pos  = epos;
            end
        end
        // R3 / R7: strobes exactly one cycle after a parity-position beat
        chk(tag, 32'(chk0_valid), 32'(rpt));
        chk(tag, 32'(chk1_valid), 32'(rpt));
        // R4: mismatch flags
        chk("R4", 32'(chk0_err), 32'(e[0]));
        chk("R4", 32'(chk1_err), 32'(e[1]));
        if (rpt) begin
            // R2: channel indices by lane
            chk("R2", 32'(chk0_chan), 32'(ch[0]));
            chk("R2", 32'(chk1_chan), 32'(ch[1]));
        end
    endtask

    task automatic run_frame(int gap, int cor, string tag);
        for (int k = 0; k < FB * NP; k++) begin
            while (($urandom % 100) < gap) beat(1'b0, 1'($urandom % 2), 0, "R6");
            beat(1'b1, k == 0, cor, tag);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        frame_start = 1'b0;
        m_st = 0; m_pair = 0; m_pos = 0;
        for (int c = 0; c < NCH; c++) m_acc[c] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs low in reset
        chk("R1", 32'(chk0_valid), 0);
        chk("R1", 32'(chk1_valid), 0);
        chk("R1", 32'(chk0_err), 0);
        chk("R1", 32'(chk1_err), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", 32'(chk0_valid), 0);
        chk("R1", 32'(chk1_err), 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R5: hunting beats, then priming frame with bad parity
        for (int i = 0; i < 5; i++) beat(1'b1, 1'b0, 100, "R5");
        run_frame(0, 100, "R5");
        // R3: clean frame, then R8 all-corrupt frame
        run_frame(0, 0, "R3");
        run_frame(0, 100, "R8");
        // R6 gaps with random corruption
        for (int f = 0; f < 6; f++) run_frame(25, 30, "R3");
        // R9: realignment in mid-frame
        for (int i = 0; i < 7; i++) beat(1'b1, 1'b0, 30, "R9");
        run_frame(10, 30, "R9");
        for (int i = 0; i < 15; i++) beat(1'b1, 1'b0, 30, "R9");
        run_frame(10, 30, "R9");
        run_frame(10, 50, "R9");
        // reset again mid-stream
        for (int i = 0; i < 3; i++) beat(1'b1, 1'b0, 50, "R3");
        do_reset();
        run_frame(0, 100, "R5");
        run_frame(0, 100, "R4");
        run_frame(20, 40, "R7");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule